// File: doc/BRIEF.md
# Supply Monitor Mode Sequencer

This block is the digital controller for a supply-voltage monitor. It picks which of two 2-bit configuration fields applies, based on the power state. One field covers the running and idle states. The other covers every deeper sleep state. The chosen field sets how the monitor is powered. In continuous mode the enable line is held high. In sampled mode it pulses for one cycle at each rising edge of a slow low-power tick. In disabled mode it stays low. The analog comparator is outside the block and arrives as a single digital undervoltage flag.

The comparator is read only while the enable line is high. Any undervoltage seen then latches a reset request. The latch also forces the monitor into continuous operation, whatever the configuration says. The request stays up until the flag clears. The block then drops the request and returns to the mode configured for the present power state. In sampled mode, a dip that starts and ends between two tick edges is never seen.

Top module: `bod_seq`

## Requirements
- R1: Field encoding is 2'b01 sampled, 2'b10 disabled and 2'b11 enabled. Code 2'b00 is reserved and behaves exactly as disabled. `mode_o` reports the effective mode in the same encoding, and shows 2'b10 for the reserved code.
- R2: When `sleep_i` is 0 (running) or 1 (idle), `act_cfg_i` applies. Any other `sleep_i` value selects `slp_cfg_i`. A change of `sleep_i` or of a field shows on `mode_o` after the next clock edge.
- R3: In enabled mode, `det_en_o` is high in every cycle.
- R4: In sampled mode, a rising edge on `tick_i` passes through a two-stage synchronizer. `det_en_o` is then high for exactly the one cycle after the second clock edge following the rise.
- R5: In sampled mode, if `uv_i` is high at the clock edge that ends the enable pulse, then after that edge `rst_req_o` is 1, `mode_o` is 2'b11 and `det_en_o` is held high.
- R6: In sampled mode, an undervoltage that rises and falls entirely between enable pulses raises no reset request.
- R7: While a request is latched, `rst_req_o` stays high for as long as `uv_i` is high at each edge. After the first edge with `uv_i` low, the request clears and `mode_o` returns to the configured mode.
- R8: In disabled or reserved mode with no request latched, `det_en_o` stays 0 and `uv_i` never raises `rst_req_o`, whether or not ticks arrive.
- R9: In enabled mode, `uv_i` high at a clock edge raises `rst_req_o` after that edge.
- R10: While `rst_ni` is low, `det_en_o` is 0, `rst_req_o` is 0 and `mode_o` is 2'b10.
- R11: A `tick_i` held high gives one enable pulse only. A new pulse needs a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_cfg_i | input | 2 | Mode field for running and idle states |
| slp_cfg_i | input | 2 | Mode field for deeper sleep states |
| sleep_i | input | 3 | Power state code: 0 running, 1 idle, others sleep |
| tick_i | input | 1 | Slow low-power tick, asynchronous |
| uv_i | input | 1 | Comparator flag, 1 = supply below threshold |
| det_en_o | output | 1 | Monitor enable |
| rst_req_o | output | 1 | Reset request |
| mode_o | output | 2 | Effective mode |

## Verification
Two functions can land on the same edge: the sampled-mode enable pulse and undervoltage detection. When both occur, the block must latch the request and switch to continuous operation at that one edge. The bench holds `uv_i` low through the cycle where the pulse first appears, then raises it for the edge that closes the pulse. It expects the request, mode 2'b11 and a steady enable right after that edge. It also raises `uv_i` well away from any pulse and expects no request, which shows that the detection depends on the pulse and not on the flag alone.

// File: rtl/bod_pkg.sv
package bod_pkg;

  typedef enum logic [1:0] {
    BOD_RSVD = 2'b00,
    BOD_SMPL = 2'b01,
    BOD_OFF  = 2'b10,
    BOD_ON   = 2'b11
  } bod_mode_e;

  // reserved code folds onto disabled
  function automatic bod_mode_e norm_mode(input logic [1:0] fld);
    bod_mode_e m;
    m = bod_mode_e'(fld);
    if (m == BOD_RSVD) m = BOD_OFF;
    return m;
  endfunction

endpackage

// File: rtl/bod_mode_sel.sv
module bod_mode_sel
  import bod_pkg::*;
#(
  parameter int unsigned SLEEP_W   = 3,
  parameter int unsigned RUN_CODE  = 0,
  parameter int unsigned IDLE_CODE = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         act_cfg_i,
  input  logic [1:0]         slp_cfg_i,
  input  logic [SLEEP_W-1:0] sleep_i,
  output bod_mode_e          cfg_o
);

  localparam logic [SLEEP_W-1:0] RunSt  = SLEEP_W'(RUN_CODE);
  localparam logic [SLEEP_W-1:0] IdleSt = SLEEP_W'(IDLE_CODE);

  logic      awake;
  bod_mode_e cfg_d, cfg_q;

  assign awake = (sleep_i == RunSt) || (sleep_i == IdleSt);
  assign cfg_d = norm_mode(awake ? act_cfg_i : slp_cfg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= BOD_OFF;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  // R1: reserved code never reaches the sequencer
  a_r1_no_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q != BOD_RSVD);

  // R2: field change is visible one edge later
  a_r2_field_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awake && (norm_mode(act_cfg_i) == BOD_ON) |=> cfg_q == BOD_ON);

endmodule

// File: rtl/bod_tick_edge.sv
module bod_tick_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic edge_o
);

  localparam int unsigned Last = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= tick_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[Last];
    end
  end

  assign edge_o = sync_q[Last] & ~prev_q;

  // R11: a level tick yields a single strobe
  a_r11_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);

endmodule

// File: rtl/bod_core.sv
module bod_core
  import bod_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  bod_mode_e cfg_i,
  input  logic      edge_i,
  input  logic      uv_i,
  output logic      det_en_o,
  output logic      rst_req_o,
  output bod_mode_e mode_o
);

  logic cfg_on, cfg_smpl;
  logic hold_q;

  assign cfg_on   = (cfg_i == BOD_ON);
  assign cfg_smpl = (cfg_i == BOD_SMPL);

  // latched detection forces continuous powering
  assign det_en_o = hold_q | cfg_on | (cfg_smpl & edge_i);

  // comparator is only trusted while the monitor is powered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= uv_i & det_en_o;
  end

  assign rst_req_o = hold_q;
  assign mode_o    = hold_q ? BOD_ON : cfg_i;

  // R5: detection on the sample edge latches the request
  a_r5_sample_catch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_smpl && edge_i && uv_i |=> hold_q);

  // R7: recovery releases the request
  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q && !uv_i |=> !hold_q);

  // R8: disabled mode never raises a request
  a_r8_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == BOD_OFF) && !hold_q |=> !hold_q);

  // R6: undervoltage outside a sample is ignored
  a_r6_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_smpl && !edge_i && !hold_q |=> !hold_q);

endmodule

// File: rtl/bod_seq.sv
module bod_seq
  import bod_pkg::*;
#(
  parameter int unsigned SLEEP_W     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         act_cfg_i,
  input  logic [1:0]         slp_cfg_i,
  input  logic [SLEEP_W-1:0] sleep_i,
  input  logic               tick_i,
  input  logic               uv_i,
  output logic               det_en_o,
  output logic               rst_req_o,
  output logic [1:0]         mode_o
);

  bod_mode_e cfg_w, mode_w;
  logic      edge_w;

  bod_mode_sel #(.SLEEP_W(SLEEP_W)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_cfg_i (act_cfg_i),
    .slp_cfg_i (slp_cfg_i),
    .sleep_i   (sleep_i),
    .cfg_o     (cfg_w)
  );

  bod_tick_edge #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .edge_o (edge_w)
  );

  bod_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg_w),
    .edge_i    (edge_w),
    .uv_i      (uv_i),
    .det_en_o  (det_en_o),
    .rst_req_o (rst_req_o),
    .mode_o    (mode_w)
  );

  assign mode_o = mode_w;

  // R5: a pending request always keeps the monitor powered
  a_r5_req_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> det_en_o && (mode_o == 2'b11));

  // R10: reset leaves the block quiet
  always_comb begin
    if (!rst_ni) a_r10_reset_quiet: assert (!rst_req_o);
  end

endmodule

// File: tb/sim_bod_seq.sv
`timescale 1ns/1ps
module sim_bod_seq;

  typedef struct {
    logic       en;
    logic       rq;
    logic [1:0] md;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] act_cfg = 2'b11;
  logic [1:0] slp_cfg = 2'b01;
  logic [2:0] sleep = 3'd0;
  logic       tick = 1'b0;
  logic       uv = 1'b0;
  logic       det_en, rst_req;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;

  bod_seq u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .act_cfg_i (act_cfg),
    .slp_cfg_i (slp_cfg),
    .sleep_i   (sleep),
    .tick_i    (tick),
    .uv_i      (uv),
    .det_en_o  (det_en),
    .rst_req_o (rst_req),
    .mode_o    (mode)
  );

  task automatic cmp(input string tag, input logic en, input logic rq, input logic [1:0] md);
    checks++;
    if (det_en !== en || rst_req !== rq || mode !== md) begin
      errors++;
      $display("FAIL %s: got en=%b req=%b mode=%b, expected en=%b req=%b mode=%b",
               tag, det_en, rst_req, mode, en, rq, md);
    end
  endtask

  // driver: set inputs at negedge, queue what must follow the next edge
  task automatic step(input logic [1:0] a, input logic [1:0] s, input logic [2:0] sl,
                      input logic t, input logic u,
                      input logic en, input logic rq, input logic [1:0] md, input string tag);
    exp_t e;
    @(negedge clk);
    act_cfg = a; slp_cfg = s; sleep = sl; tick = t; uv = u;
    e.en = en; e.rq = rq; e.md = md; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, e.en, e.rq, e.md);
      end
    end
  end

  initial begin
    #(8 * 2000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 cmp("R10 reset", 1'b0, 1'b0, 2'b10);
    @(negedge clk) rst_n = 1'b1;

    // running state, enabled field
    step(2'b11, 2'b01, 3'd0, 0, 0, 1, 0, 2'b11, "R3 enabled");
    step(2'b11, 2'b01, 3'd0, 0, 1, 1, 1, 2'b11, "R9 uv in enabled");
    step(2'b11, 2'b01, 3'd0, 0, 1, 1, 1, 2'b11, "R7 held");
    step(2'b11, 2'b01, 3'd0, 0, 0, 1, 0, 2'b11, "R7 release");
    step(2'b11, 2'b01, 3'd1, 0, 0, 1, 0, 2'b11, "R2 idle uses active field");
    // deep sleep -> sampled
    step(2'b11, 2'b01, 3'd3, 0, 0, 0, 0, 2'b01, "R2 sleep field");
    step(2'b11, 2'b01, 3'd3, 0, 1, 0, 0, 2'b01, "R6 dip");
    step(2'b11, 2'b01, 3'd3, 0, 0, 0, 0, 2'b01, "R6 dip gone");
    step(2'b11, 2'b01, 3'd3, 1, 0, 0, 0, 2'b01, "R4 sync stage");
    step(2'b11, 2'b01, 3'd3, 1, 0, 1, 0, 2'b01, "R4 pulse");
    step(2'b11, 2'b01, 3'd3, 1, 0, 0, 0, 2'b01, "R11 level tick");
    step(2'b11, 2'b01, 3'd3, 1, 0, 0, 0, 2'b01, "R11 level tick");
    step(2'b11, 2'b01, 3'd3, 0, 0, 0, 0, 2'b01, "R4 tick low");
    step(2'b11, 2'b01, 3'd3, 0, 0, 0, 0, 2'b01, "R4 tick low");
    step(2'b11, 2'b01, 3'd3, 1, 0, 0, 0, 2'b01, "R4 second rise");
    step(2'b11, 2'b01, 3'd3, 1, 0, 1, 0, 2'b01, "R4 second pulse");
    step(2'b11, 2'b01, 3'd3, 1, 1, 1, 1, 2'b11, "R5 sample detect");
    step(2'b11, 2'b01, 3'd3, 1, 1, 1, 1, 2'b11, "R7 held continuous");
    step(2'b11, 2'b01, 3'd3, 1, 0, 0, 0, 2'b01, "R7 back to sampled");
    step(2'b11, 2'b01, 3'd3, 0, 0, 0, 0, 2'b01, "R4 idle");
    // disabled and reserved
    step(2'b11, 2'b10, 3'd3, 0, 1, 0, 0, 2'b10, "R8 disabled");
    step(2'b11, 2'b10, 3'd3, 1, 1, 0, 0, 2'b10, "R8 uv ignored");
    step(2'b11, 2'b10, 3'd3, 1, 1, 0, 0, 2'b10, "R8 tick ignored");
    step(2'b11, 2'b00, 3'd3, 0, 1, 0, 0, 2'b10, "R1 reserved");
    step(2'b11, 2'b00, 3'd3, 1, 1, 0, 0, 2'b10, "R1 reserved uv");
    step(2'b11, 2'b00, 3'd5, 1, 0, 0, 0, 2'b10, "R1 reserved quiet");
    step(2'b10, 2'b00, 3'd0, 0, 1, 0, 0, 2'b10, "R8 active disabled");

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule